// File: doc/BRIEF.md
# Parallel Flash Programming Command Sequencer

This block sits on the device side of a parallel programming port. A host presents a small MODE tag together with a DATA word and pulses a strobe; the block takes one word per strobe edge and drops its ready output while it acts on that word. A run of tagged words forms a command. A command word opens the run and names the operation. For memory writes it is followed by the low and high halves of a start address and then by any number of data words. Each data word becomes a one-cycle write request, and the address advances by one after every request.

Two flash controller ports share the request outputs, and a select line steers each request. A controller-select command picks which controller receives the page-write, erase-all, lock-bit and general-purpose-bit commands. Memory writes go to the selected controller too. A set-security command sends its request to controller 0 and then locks the port completely. Only a full erase can open the port again: the erase input must stay asserted for longer than a parameterised number of cycles. That erase also returns the selection to controller 0 and resets the parser.

Top module: `prog_port_seq`

## Requirements
- R1: A word is taken only on a rising edge of `host_stb` seen while `host_rdy` is high. `host_rdy` is low from that point until the resulting request or flag update has been issued. A strobe held high for several cycles is taken once.
- R2: After reset `host_rdy`=1, `wr_stb`=0, `cmd_stb`=0, `err`=0, `secured`=0, and controller 0 is selected.
- R3: With the default tags (command=1, address-low=2, address-high=3, data=5) and command opcode 0x10 (memory write), the sequence command, address-low L, address-high H, data D gives one `wr_stb` pulse with `wr_addr`={H,L} and `wr_data`=D.
- R4: Each further data word in the same chain is written to the previous address plus one, wrapping from 0xFFFFFFFF to 0.
- R5: A data word that arrives before the address phase is complete, an address word that is out of order, a command word with an unknown opcode, and any tag other than 1, 2, 3 or 5 all set `err` and produce no request. `err` stays set until the next command word is taken.
- R6: A command word taken in the middle of a chain ends that chain, so a data word that follows a fresh memory-write command with no address is flagged by R5.
- R7: Opcode 0x20 (select) followed by a data word of 0 or 1 selects controller 0 or 1. Any other value sets `err` and leaves the selection unchanged.
- R8: Opcodes 0x41, 0x42, 0x43 and 0x44 (page write, erase all, lock bit, general-purpose bit), each followed by one data word, give one `cmd_stb` pulse. The pulse carries `cmd_op` equal to the opcode, `wr_data` equal to the word and `wr_sel` equal to the current selection.
- R9: Opcode 0x30 (security) with data 0 gives one `cmd_stb` pulse with `wr_sel`=0 and sets `secured`. From then on `host_rdy` stays low and every strobe is ignored. A nonzero data word sets `err` instead.
- R10: While `secured` is set, holding `erase_in` high for more than ERASE_CYC consecutive cycles clears `secured`, selects controller 0 and restarts the parser. Holding it for ERASE_CYC cycles or fewer does nothing.
- R11: `wr_stb` and `cmd_stb` last one cycle each and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stb | input | 1 | Host write strobe; a rising edge offers a word |
| host_mode | input | 4 | Tag of the offered word |
| host_data | input | 16 | Offered data word |
| host_rdy | output | 1 | High when a new word may be offered |
| erase_in | input | 1 | Full-erase request, level sensitive |
| wr_stb | output | 1 | One-cycle memory write request |
| cmd_stb | output | 1 | One-cycle controller command request |
| wr_sel | output | 1 | Controller addressed by the current request |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 16 | Write data or command argument |
| cmd_op | output | 8 | Opcode of a controller command |
| err | output | 1 | Sticky protocol error flag |
| secured | output | 1 | Port locked by the security command |

## Verification
On every cycle the assertions check that the two request strobes are single pulses that never overlap. They also check that a request only follows a cycle in which ready was low, that a locked port keeps ready low and issues no memory writes, that locking coincides with a security request to controller 0, and that a rising error flag comes with no request. The bench scenarios are the only way to show that the data path is right. These cover address assembly and increment across the 32-bit wrap, the tracking of controller selection, the rejection of every illegal tag value, the abort of a chain on a new command, and the exact erase hold length that reopens the port.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_CMD    = 2'd1,
      PH_ALO    = 2'd2,
      PH_STREAM = 2'd3
   } phase_t;

endpackage

// File: rtl/prog_seq_front.sv
module prog_seq_front #(
   parameter int DATA_W      = 16,
   parameter int MODE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_stb,
   input  logic [MODE_W-1:0] host_mode,
   input  logic [DATA_W-1:0] host_data,
   input  logic              lock,
   output logic              host_rdy,
   output logic              word_vld,
   output logic [MODE_W-1:0] word_mode,
   output logic [DATA_W-1:0] word_data
);

   logic stb_s;
   logic stb_prev;
   logic take;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign stb_s = host_stb;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2+1-1:0], host_stb};
         end
         assign stb_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign host_rdy = !word_vld && !lock;
   assign take     = stb_s && !stb_prev && host_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_prev  <= 1'b0;
         word_vld  <= 1'b0;
         word_mode <= '0;
         word_data <= '0;
      end else begin
         stb_prev <= stb_s;
         word_vld <= take;
         if (take) begin
            word_mode <= host_mode;
            word_data <= host_data;
         end
      end
   end

endmodule

// File: rtl/prog_seq_parse.sv
module prog_seq_parse
   import prog_seq_pkg::*;
#(
   parameter int          DATA_W  = 16,
   parameter int          ADDR_W  = 32,
   parameter int          MODE_W  = 4,
   parameter int          OP_W    = 8,
   parameter logic [3:0]  MD_CMD  = 4'd1,
   parameter logic [3:0]  MD_ALO  = 4'd2,
   parameter logic [3:0]  MD_AHI  = 4'd3,
   parameter logic [3:0]  MD_DAT  = 4'd5,
   parameter logic [7:0]  OP_WRAM = 8'h10,
   parameter logic [7:0]  OP_SEL  = 8'h20,
   parameter logic [7:0]  OP_SEC  = 8'h30,
   parameter logic [7:0]  OP_WP   = 8'h41,
   parameter logic [7:0]  OP_EA   = 8'h42,
   parameter logic [7:0]  OP_LB   = 8'h43,
   parameter logic [7:0]  OP_GPB  = 8'h44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld,
   input  logic [MODE_W-1:0] word_mode,
   input  logic [DATA_W-1:0] word_data,
   input  logic              wipe,
   output logic              sec_hit,
   output logic              wr_stb,
   output logic              cmd_stb,
   output logic              wr_sel,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [OP_W-1:0]   cmd_op,
   output logic              err
);

   localparam int HI_W = ADDR_W - DATA_W;

   phase_t            phase;
   logic [OP_W-1:0]   op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              sel_q;
   logic              op_known;
   logic              is_ctl_op;
   logic [OP_W-1:0]   new_op;

   assign new_op    = word_data[OP_W-1:0];
   assign is_ctl_op = (op_q == OP_W'(OP_WP)) || (op_q == OP_W'(OP_EA)) ||
                      (op_q == OP_W'(OP_LB)) || (op_q == OP_W'(OP_GPB));
   assign op_known  = (new_op == OP_W'(OP_WRAM)) || (new_op == OP_W'(OP_SEL)) ||
                      (new_op == OP_W'(OP_SEC))  || (new_op == OP_W'(OP_WP))  ||
                      (new_op == OP_W'(OP_EA))   || (new_op == OP_W'(OP_LB))  ||
                      (new_op == OP_W'(OP_GPB));

   assign sec_hit = word_vld && !wipe && (word_mode == MODE_W'(MD_DAT)) &&
                    (phase == PH_CMD) && (op_q == OP_W'(OP_SEC)) && (word_data == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         op_q    <= '0;
         addr_q  <= '0;
         sel_q   <= 1'b0;
         wr_stb  <= 1'b0;
         cmd_stb <= 1'b0;
         wr_sel  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         cmd_op  <= '0;
         err     <= 1'b0;
      end else begin
         wr_stb  <= 1'b0;
         cmd_stb <= 1'b0;
         if (wipe) begin
            phase <= PH_IDLE;
            sel_q <= 1'b0;
            err   <= 1'b0;
         end else if (word_vld) begin
            if (word_mode == MODE_W'(MD_CMD)) begin
               op_q  <= new_op;
               phase <= op_known ? PH_CMD : PH_IDLE;
               err   <= !op_known;
            end else if (word_mode == MODE_W'(MD_ALO)) begin
               if (phase == PH_CMD && op_q == OP_W'(OP_WRAM)) begin
                  addr_q[DATA_W-1:0] <= word_data;
                  phase              <= PH_ALO;
               end else begin
                  err <= 1'b1;
               end
            end else if (word_mode == MODE_W'(MD_AHI)) begin
               if (phase == PH_ALO) begin
                  addr_q[ADDR_W-1:DATA_W] <= word_data[HI_W-1:0];
                  phase                   <= PH_STREAM;
               end else begin
                  err <= 1'b1;
               end
            end else if (word_mode == MODE_W'(MD_DAT)) begin
               if (phase == PH_STREAM) begin
                  wr_stb  <= 1'b1;
                  wr_sel  <= sel_q;
                  wr_addr <= addr_q;
                  wr_data <= word_data;
                  addr_q  <= addr_q + 1'b1;
               end else if (phase == PH_CMD && op_q == OP_W'(OP_SEL)) begin
                  if (word_data <= DATA_W'(1)) sel_q <= word_data[0];
                  else                         err   <= 1'b1;
                  phase <= PH_IDLE;
               end else if (phase == PH_CMD && op_q == OP_W'(OP_SEC)) begin
                  if (word_data == '0) begin
                     cmd_stb <= 1'b1;
                     wr_sel  <= 1'b0;
                     cmd_op  <= op_q;
                     wr_data <= word_data;
                  end else begin
                     err <= 1'b1;
                  end
                  phase <= PH_IDLE;
               end else if (phase == PH_CMD && is_ctl_op) begin
                  cmd_stb <= 1'b1;
                  wr_sel  <= sel_q;
                  cmd_op  <= op_q;
                  wr_data <= word_data;
                  phase   <= PH_IDLE;
               end else begin
                  err <= 1'b1;
               end
            end else begin
               err <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/prog_seq_guard.sv
module prog_seq_guard #(
   parameter int unsigned ERASE_CYC = 11_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_hit,
   input  logic erase_in,
   output logic secured,
   output logic wipe
);

   localparam int CNT_W = $clog2(ERASE_CYC + 2) + 1;

   logic [CNT_W-1:0] hold_cnt;

   assign wipe = secured && erase_in && (hold_cnt == CNT_W'(ERASE_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         secured  <= 1'b0;
      end else begin
         if (!erase_in)                             hold_cnt <= '0;
         else if (hold_cnt <= CNT_W'(ERASE_CYC))    hold_cnt <= hold_cnt + 1'b1;
         if (wipe)         secured <= 1'b0;
         else if (sec_hit) secured <= 1'b1;
      end
   end

endmodule

// File: rtl/prog_port_seq.sv
module prog_port_seq #(
   parameter int          DATA_W      = 16,
   parameter int          ADDR_W      = 32,
   parameter int          MODE_W      = 4,
   parameter int          OP_W        = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned ERASE_CYC   = 11_000_000,
   parameter logic [3:0]  MD_CMD      = 4'd1,
   parameter logic [3:0]  MD_ALO      = 4'd2,
   parameter logic [3:0]  MD_AHI      = 4'd3,
   parameter logic [3:0]  MD_DAT      = 4'd5,
   parameter logic [7:0]  OP_WRAM     = 8'h10,
   parameter logic [7:0]  OP_SEL      = 8'h20,
   parameter logic [7:0]  OP_SEC      = 8'h30,
   parameter logic [7:0]  OP_WP       = 8'h41,
   parameter logic [7:0]  OP_EA       = 8'h42,
   parameter logic [7:0]  OP_LB       = 8'h43,
   parameter logic [7:0]  OP_GPB      = 8'h44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_stb,
   input  logic [MODE_W-1:0] host_mode,
   input  logic [DATA_W-1:0] host_data,
   output logic              host_rdy,
   input  logic              erase_in,
   output logic              wr_stb,
   output logic              cmd_stb,
   output logic              wr_sel,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [OP_W-1:0]   cmd_op,
   output logic              err,
   output logic              secured
);

   generate
      if (ADDR_W <= DATA_W || ADDR_W > 2 * DATA_W) begin : g_bad_addr
         $fatal(1, "ADDR_W must lie above DATA_W and at most twice it");
      end
      if (MODE_W < 1 || MODE_W > 4) begin : g_bad_mode
         $fatal(1, "MODE_W must be 1 to 4");
      end
      if (OP_W < 1 || OP_W > 8 || OP_W > DATA_W) begin : g_bad_op
         $fatal(1, "OP_W must be 1 to 8 and fit in DATA_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $fatal(1, "SYNC_STAGES must be 0 to 3");
      end
      if (ERASE_CYC < 1) begin : g_bad_erase
         $fatal(1, "ERASE_CYC must be at least 1");
      end
   endgenerate

   logic              word_vld;
   logic [MODE_W-1:0] word_mode;
   logic [DATA_W-1:0] word_data;
   logic              sec_hit;
   logic              wipe;

   prog_seq_front #(
      .DATA_W      (DATA_W),
      .MODE_W      (MODE_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_stb  (host_stb),
      .host_mode (host_mode),
      .host_data (host_data),
      .lock      (secured),
      .host_rdy  (host_rdy),
      .word_vld  (word_vld),
      .word_mode (word_mode),
      .word_data (word_data)
   );

   prog_seq_parse #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .MODE_W  (MODE_W),
      .OP_W    (OP_W),
      .MD_CMD  (MD_CMD),
      .MD_ALO  (MD_ALO),
      .MD_AHI  (MD_AHI),
      .MD_DAT  (MD_DAT),
      .OP_WRAM (OP_WRAM),
      .OP_SEL  (OP_SEL),
      .OP_SEC  (OP_SEC),
      .OP_WP   (OP_WP),
      .OP_EA   (OP_EA),
      .OP_LB   (OP_LB),
      .OP_GPB  (OP_GPB)
   ) u_parse (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_vld  (word_vld),
      .word_mode (word_mode),
      .word_data (word_data),
      .wipe      (wipe),
      .sec_hit   (sec_hit),
      .wr_stb    (wr_stb),
      .cmd_stb   (cmd_stb),
      .wr_sel    (wr_sel),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cmd_op    (cmd_op),
      .err       (err)
   );

   prog_seq_guard #(
      .ERASE_CYC (ERASE_CYC)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_hit  (sec_hit),
      .erase_in (erase_in),
      .secured  (secured),
      .wipe     (wipe)
   );

endmodule

// File: rtl/prog_port_seq_chk.sv
module prog_port_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic host_rdy,
   input logic wr_stb,
   input logic cmd_stb,
   input logic wr_sel,
   input logic err,
   input logic secured
);

   AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_stb, cmd_stb}));                                    // R11

   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);                                             // R11

   AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> !cmd_stb);                                           // R11

   AST_REQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb || cmd_stb) |-> !$past(host_rdy));                       // R1

   AST_LOCK_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      secured |-> !host_rdy);                                          // R9

   AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      secured |-> !wr_stb);                                            // R9

   AST_LOCK_VIA_CTL0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(secured) |-> (cmd_stb && !wr_sel));                        // R9

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (!wr_stb && !cmd_stb));                           // R5

endmodule

bind prog_port_seq prog_port_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_rdy (host_rdy),
   .wr_stb   (wr_stb),
   .cmd_stb  (cmd_stb),
   .wr_sel   (wr_sel),
   .err      (err),
   .secured  (secured)
);

// File: tb/tb_prog_port_seq.sv
`timescale 1ns/1ps
module tb_prog_port_seq;

   localparam int ECYC = 24;
   localparam logic [3:0] M_CMD = 4'd1, M_ALO = 4'd2, M_AHI = 4'd3, M_DAT = 4'd5;
   localparam logic [15:0] O_WRAM = 16'h10, O_SEL = 16'h20, O_SEC = 16'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_stb = 1'b0;
   logic [3:0]  host_mode = '0;
   logic [15:0] host_data = '0;
   logic        host_rdy;
   logic        erase_in = 1'b0;
   logic        wr_stb, cmd_stb, wr_sel, err, secured;
   logic [31:0] wr_addr;
   logic [15:0] wr_data;
   logic [7:0]  cmd_op;

   int checks = 0;
   int fails  = 0;
   int ev_n   = 0;
   logic        ev_kind [0:255];
   logic        ev_sel  [0:255];
   logic [31:0] ev_addr [0:255];
   logic [15:0] ev_data [0:255];
   logic [7:0]  ev_op   [0:255];

   always #2.5 clk = ~clk;

   prog_port_seq #(.ERASE_CYC(ECYC)) dut (
      .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_mode(host_mode),
      .host_data(host_data), .host_rdy(host_rdy), .erase_in(erase_in),
      .wr_stb(wr_stb), .cmd_stb(cmd_stb), .wr_sel(wr_sel), .wr_addr(wr_addr),
      .wr_data(wr_data), .cmd_op(cmd_op), .err(err), .secured(secured)
   );

   always @(negedge clk) begin
      if (rst_n && (wr_stb || cmd_stb) && ev_n < 256) begin
         ev_kind[ev_n] = cmd_stb;
         ev_sel[ev_n]  = wr_sel;
         ev_addr[ev_n] = wr_addr;
         ev_data[ev_n] = wr_data;
         ev_op[ev_n]   = cmd_op;
         ev_n = ev_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [3:0] m, input logic [15:0] d);
      @(negedge clk);
      host_mode = m;
      host_data = d;
      host_stb  = 1'b1;
      repeat (5) @(negedge clk);
      host_stb = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic chk_ev(input int i, input bit kind, input bit sel, input logic [31:0] a,
                         input logic [15:0] d, input logic [7:0] op, input string req);
      chk(i < ev_n, req, "request missing", ev_n, i + 1);
      if (i < ev_n) begin
         chk(ev_kind[i] == kind, req, "request kind", ev_kind[i], kind);
         chk(ev_sel[i] == sel, req, "controller select", ev_sel[i], sel);
         chk(ev_data[i] == d, req, "data", ev_data[i], d);
         if (kind) chk(ev_op[i] == op, req, "opcode", ev_op[i], op);
         else      chk(ev_addr[i] == a, req, "address", ev_addr[i], a);
      end
   endtask

   task automatic chain(input logic [31:0] a, input int n, input logic [15:0] seed, input bit sel);
      int base;
      base = ev_n;
      send(M_CMD, O_WRAM);
      send(M_ALO, a[15:0]);
      send(M_AHI, a[31:16]);
      for (int i = 0; i < n; i++) send(M_DAT, seed ^ 16'(i * 16'h0111));
      chk(ev_n - base == n, "R3", "write count", ev_n - base, n);
      for (int i = 0; i < n; i++)
         chk_ev(base + i, 1'b0, sel, a + 32'(i), seed ^ 16'(i * 16'h0111), 8'h0,
                (i == 0) ? "R3" : "R4");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : stim
      int base;
      bit saw_busy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk(host_rdy == 1'b1, "R2", "ready after reset", host_rdy, 1);
      chk(!wr_stb && !cmd_stb, "R2", "strobes after reset", {wr_stb, cmd_stb}, 0);
      chk(err == 1'b0, "R2", "err after reset", err, 0);
      chk(secured == 1'b0, "R2", "secured after reset", secured, 0);

      // R1 ready drops after a taken word, one word per held strobe
      base = ev_n;
      saw_busy = 1'b0;
      send(M_CMD, O_WRAM);
      @(negedge clk);
      host_mode = M_ALO; host_data = 16'h1234; host_stb = 1'b1;
      repeat (8) begin @(negedge clk); if (!host_rdy) saw_busy = 1'b1; end
      host_stb = 1'b0;
      repeat (4) @(negedge clk);
      chk(saw_busy, "R1", "ready low after taking a word", saw_busy, 1);
      chk(host_rdy, "R1", "ready back high", host_rdy, 1);
      send(M_AHI, 16'h0000);
      send(M_DAT, 16'hBEEF);
      chk(ev_n - base == 1, "R1", "one request per held strobe", ev_n - base, 1);
      chk_ev(base, 1'b0, 1'b0, 32'h0000_1234, 16'hBEEF, 8'h0, "R3");

      // R3/R4 chain length and address sweep, including the 32-bit wrap
      for (int n = 1; n <= 5; n++) chain(32'h0001_0000 * 32'(n) + 32'(n * 7), n, 16'(n * 16'h1357), 1'b0);
      chain(32'hFFFF_FFFE, 4, 16'hA5A5, 1'b0);
      chain(32'h0000_FFFF, 3, 16'h0F0F, 1'b0);

      // R7 controller select sweep
      for (int v = 0; v < 4; v++) begin
         bit exp_sel;
         send(M_CMD, O_SEL);
         send(M_DAT, 16'(v));
         exp_sel = (v == 0) ? 1'b0 : 1'b1;
         chk(err == (v > 1), "R7", "err on select value", err, v > 1);
         chain(32'h0000_0100 + 32'(v), 1, 16'(16'h4400 + v), exp_sel);
      end

      // R8 controller commands to both controllers
      for (int s = 0; s < 2; s++) begin
         send(M_CMD, O_SEL);
         send(M_DAT, 16'(s));
         for (int k = 0; k < 4; k++) begin
            base = ev_n;
            send(M_CMD, 16'h41 + 16'(k));
            send(M_DAT, 16'(16'h0C00 + s * 16 + k));
            chk(ev_n - base == 1, "R8", "one command request", ev_n - base, 1);
            chk_ev(base, 1'b1, 1'(s), 32'h0, 16'(16'h0C00 + s * 16 + k), 8'(8'h41 + k), "R8");
         end
      end

      // R5 illegal tag sweep; R5 cleared on next command
      for (int m = 0; m < 16; m++) begin
         if (m != 1 && m != 2 && m != 3 && m != 5) begin
            send(M_CMD, O_WRAM);
            chk(err == 1'b0, "R5", "err cleared by command", err, 0);
            base = ev_n;
            send(4'(m), 16'h5555);
            chk(err == 1'b1, "R5", "err on illegal tag", err, 1);
            chk(ev_n == base, "R5", "no request on illegal tag", ev_n - base, 0);
         end
      end
      send(M_CMD, 16'h00EE);
      chk(err == 1'b1, "R5", "err on unknown opcode", err, 1);
      send(M_CMD, O_WRAM);
      send(M_AHI, 16'h0001);
      chk(err == 1'b1, "R5", "err on high address first", err, 1);

      // R6 a new command aborts the chain
      send(M_CMD, O_SEL);
      send(M_DAT, 16'h0);
      chain(32'h0000_2000, 2, 16'h7777, 1'b0);
      base = ev_n;
      send(M_CMD, O_WRAM);
      send(M_DAT, 16'h9999);
      chk(err == 1'b1, "R6", "data after new command flagged", err, 1);
      chk(ev_n == base, "R6", "no write after abort", ev_n - base, 0);

      // R9 security, nonzero value first
      send(M_CMD, O_SEC);
      send(M_DAT, 16'h0001);
      chk(err == 1'b1 && secured == 1'b0, "R9", "nonzero security value", {err, secured}, 2);
      send(M_CMD, O_SEL);
      send(M_DAT, 16'h1);
      base = ev_n;
      send(M_CMD, O_SEC);
      send(M_DAT, 16'h0000);
      chk(secured == 1'b1, "R9", "secured set", secured, 1);
      chk_ev(base, 1'b1, 1'b0, 32'h0, 16'h0, 8'h30, "R9");
      chk(host_rdy == 1'b0, "R9", "ready low when secured", host_rdy, 0);
      base = ev_n;
      send(M_CMD, O_WRAM);
      send(M_ALO, 16'h0);
      send(M_AHI, 16'h0);
      send(M_DAT, 16'h1111);
      send(M_CMD, 16'h42);
      send(M_DAT, 16'h2222);
      chk(ev_n == base, "R9", "no request while secured", ev_n - base, 0);

      // R10 erase hold of exactly ECYC cycles leaves the lock
      @(negedge clk);
      erase_in = 1'b1;
      repeat (ECYC) @(negedge clk);
      erase_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(secured == 1'b1, "R10", "short erase keeps lock", secured, 1);
      // R10 hold of ECYC+1 cycles clears it
      erase_in = 1'b1;
      repeat (ECYC + 1) @(negedge clk);
      erase_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(secured == 1'b0, "R10", "long erase clears lock", secured, 0);
      chk(host_rdy == 1'b1, "R10", "ready after erase", host_rdy, 1);
      base = ev_n;
      send(M_CMD, 16'h42);
      send(M_DAT, 16'h0042);
      chk_ev(base, 1'b1, 1'b0, 32'h0, 16'h0042, 8'h42, "R10");
      send(M_DAT, 16'h0001);
      chk(err == 1'b1, "R10", "parser idle after command", err, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule